// File: doc/BRIEF.md
# Flash Status Register Write Guard

This block keeps the status register of a serial flash device. The register holds a write-enable latch, a three-bit block-protect code and a status-write-disable bit. The block decides whether a decoded "write status" command may change the register, and it drives a write-in-progress flag while an accepted status write completes. It samples the asynchronous, active-low write-protect pin through a synchroniser. When the disable bit is set and that pin is low, the block is in hardware-protected mode.

A command decoder in front of the block supplies one-cycle request pulses: write-enable, and write-status together with its data byte. The array engines supply a busy level. A program or erase engine gives an address to the block and gets back a per-address protect flag. That flag comes from the current block-protect code and a parameter table. Each entry of the table gives the log2 size of the protected top-of-array region for one code.

Top module: `fsp_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and hw_prot is 0.
- R2: A write-enable pulse sets WEL (status bit 1) at the next clock edge, unless a busy condition is present (external busy or an internal status write cycle), in which case it is ignored.
- R3: A write-status pulse while WEL is 0 leaves the whole status byte unchanged.
- R4: A write-status pulse accepted with WEL set loads SRWD (bit 7) and BP2..BP0 (bits 4..2) from the same data bits at the next edge. Status bits 6 and 5 always read 0.
- R5: An accepted status write holds WIP (status bit 0) at 1 for WR_CYCLES samples, starting with the sample after the accepting edge. WEL clears in the same edge that ends WIP.
- R6: hw_prot is 1 exactly when SRWD is 1 and the synchronised write-protect pin is low. It reaches that state whichever of the two conditions came first. A pin change reaches hw_prot after two clock edges.
- R7: In hardware-protected mode a write-status pulse with WEL set is refused. SRWD and BP keep their values, WEL clears at the next edge, and WIP stays 0.
- R8: Once hardware-protected mode is entered, only driving the pin high leaves it. After that a status write is accepted again and may clear SRWD.
- R9: With the pin held high, hw_prot stays 0 even with SRWD at 1, and status writes are accepted.
- R10: The external busy input shows at once as status bit 0, and status writes offered during it are ignored.
- R11: addr_prot is 1 when BP code n is nonzero and the address lies in the top 2^PROT_LOG2[n] locations, with the whole array covered when that size reaches the array size. Code 0 protects nothing by default, because its entry is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_pin | input | 1 | Asynchronous active-low write-protect pin |
| ext_busy | input | 1 | Program/erase engine busy level |
| wren_req | input | 1 | Write-enable request pulse |
| wrsr_req | input | 1 | Write-status request pulse |
| wrsr_data | input | 8 | Data byte of the write-status request |
| chk_addr | input | ADDR_W | Array address under test for protection |
| status_byte | output | 8 | {SRWD, 0, 0, BP2, BP1, BP0, WEL, WIP} |
| hw_prot | output | 1 | Hardware-protected mode flag |
| addr_prot | output | 1 | chk_addr lies in the protected region |

## Verification
The assertions assume that requests are single-cycle pulses from a decoder. They also assume that write-enable and write-status never arrive in the same cycle. The bench keeps to this: it raises each pulse for one cycle, with the other request low. Pin changes are applied away from clock edges and held for at least two cycles, so the synchroniser latency is deterministic. Both orders of entry into protected mode are driven: pin first, and disable bit first.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    // Bit positions of the read-back status byte (the decoder reads these)
    localparam int unsigned SB_WIP  = 0;
    localparam int unsigned SB_WEL  = 1;
    localparam int unsigned SB_BP0  = 2;
    localparam int unsigned SB_SRWD = 7;
    localparam int unsigned BP_W    = 3;
    localparam int unsigned NCODES  = 1 << BP_W;

    // Marker in the region table meaning "code protects nothing"
    localparam logic [7:0] REGION_NONE = 8'hFF;

    typedef struct packed {
        logic            srwd;
        logic [BP_W-1:0] bp;
        logic            wel;
    } stat_t;

    function automatic logic [7:0] pack_status(stat_t s, logic wip);
        logic [7:0] b;
        b                       = '0;
        b[SB_SRWD]              = s.srwd;
        b[SB_BP0 +: BP_W]       = s.bp;
        b[SB_WEL]               = s.wel;
        b[SB_WIP]               = wip;
        return b;
    endfunction

endpackage

// File: rtl/fsp_wp_sync.sv
module fsp_wp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    // Resets high: a released pin means "not protected"
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_q[0]) |=> chain_q[1]) else $error("sync stage skipped"); // R6

endmodule

// File: rtl/fsp_region.sv
module fsp_region
    import fsp_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [NCODES-1:0][7:0] PROT_LOG2 =
        {8'd12, 8'd11, 8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'hFF}
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [NCODES-1:0] code_hit;

    for (genvar n = 0; n < NCODES; n++) begin : g_code
        localparam int unsigned L = int'(PROT_LOG2[n]);
        if (PROT_LOG2[n] == REGION_NONE) begin : g_none
            assign code_hit[n] = 1'b0;
        end else if (L >= ADDR_W) begin : g_all
            assign code_hit[n] = 1'b1;
        end else begin : g_top
            // top 2^L locations: all address bits above L are ones
            assign code_hit[n] = &addr[ADDR_W-1:L];
        end
    end

    assign hit = code_hit[bp];

    always_comb begin
        AST_ZERO_CODE_FREE: assert (!(hit && bp == '0 && PROT_LOG2[0] == REGION_NONE))
            else $error("code 0 reported protection"); // R11
    end

endmodule

// File: rtl/fsp_stat_core.sv
module fsp_stat_core
    import fsp_pkg::*;
#(
    parameter int unsigned WR_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_prot,
    input  logic       ext_busy,
    input  logic       wren_req,
    input  logic       wrsr_req,
    input  logic [7:0] wrsr_data,
    output stat_t      stat,
    output logic       wip
);
    localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);

    typedef struct packed {
        stat_t            st;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t r_d, r_q;
    logic  int_busy, busy, wrsr_go, accept, refuse, wren_go;

    always_comb begin
        int_busy = (r_q.cnt != '0);
        busy     = int_busy | ext_busy;
        wrsr_go  = wrsr_req & ~busy & r_q.st.wel;
        accept   = wrsr_go & ~hw_prot;
        refuse   = wrsr_go &  hw_prot;
        wren_go  = wren_req & ~busy & ~wrsr_req;

        r_d = r_q;
        if (int_busy) begin
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CNT_W'(1)) r_d.st.wel = 1'b0;
        end
        if (accept) begin
            r_d.st.srwd = wrsr_data[SB_SRWD];
            r_d.st.bp   = wrsr_data[SB_BP0 +: BP_W];
            r_d.cnt     = CNT_LOAD;
        end else if (refuse) begin
            r_d.st.wel  = 1'b0;
        end else if (wren_go) begin
            r_d.st.wel  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat = r_q.st;
    assign wip  = int_busy | ext_busy;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_LOAD) else $error("write counter overflow"); // R5
    AST_NOWEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_req && !r_q.st.wel && !int_busy) |=> $stable(r_q.st)) else $error("write taken without WEL"); // R3
    AST_HPM_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_req && r_q.st.wel && hw_prot && !busy) |=>
            (!r_q.st.wel && $stable(r_q.st.srwd) && $stable(r_q.st.bp) && r_q.cnt == '0)) else $error("protected write not refused"); // R7
    AST_WEL_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_busy) |-> !r_q.st.wel) else $error("WEL survived write"); // R5
    AST_BUSY_WREN: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_req && ext_busy && !int_busy && !wrsr_req) |=> $stable(r_q.st)) else $error("request taken while busy"); // R10
    AST_BUSY_STABLE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_busy && $past(int_busy)) |-> ($stable(r_q.st.srwd) && $stable(r_q.st.bp))) else $error("bits changed mid-write"); // R4

endmodule

// File: rtl/fsp_status_guard.sv
module fsp_status_guard
    import fsp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned WR_CYCLES = 8,
    parameter int unsigned SYNC_STG  = 2,
    parameter logic [NCODES-1:0][7:0] PROT_LOG2 =
        {8'd12, 8'd11, 8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'hFF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_pin,
    input  logic              ext_busy,
    input  logic              wren_req,
    input  logic              wrsr_req,
    input  logic [7:0]        wrsr_data,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              hw_prot,
    output logic              addr_prot
);
    logic  wp_n_s;
    stat_t stat;
    logic  wip;

    fsp_wp_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wp_n_pin),
        .sync_out (wp_n_s)
    );

    // Protected mode is a level: it follows both inputs, in any order
    assign hw_prot = stat.srwd & ~wp_n_s;

    fsp_stat_core #(.WR_CYCLES(WR_CYCLES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_prot   (hw_prot),
        .ext_busy  (ext_busy),
        .wren_req  (wren_req),
        .wrsr_req  (wrsr_req),
        .wrsr_data (wrsr_data),
        .stat      (stat),
        .wip       (wip)
    );

    fsp_region #(.ADDR_W(ADDR_W), .PROT_LOG2(PROT_LOG2)) u_region (
        .bp   (stat.bp),
        .addr (chk_addr),
        .hit  (addr_prot)
    );

    assign status_byte = pack_status(stat, wip);

    AST_HPM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hw_prot) |-> wp_n_s) else $error("left protected mode with pin low"); // R8
    AST_PIN_HIGH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_n_s |-> !hw_prot) else $error("protected mode with pin high"); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6:5] == 2'b00) else $error("reserved bits set"); // R4

endmodule

// File: tb/sim_fsp_status_guard.sv
module sim_fsp_status_guard;
    localparam int CLK_NS = 10;
    localparam int AW     = 12;
    localparam int WRC    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n_pin = 1'b1, ext_busy = 1'b0, wren_req = 1'b0, wrsr_req = 1'b0;
    logic [7:0] wrsr_data = '0;
    logic [AW-1:0] chk_addr = '0;
    logic [7:0] status_byte;
    logic hw_prot, addr_prot;

    always #(CLK_NS/2) clk = ~clk;

    fsp_status_guard #(.ADDR_W(AW), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_n_pin(wp_n_pin), .ext_busy(ext_busy),
        .wren_req(wren_req), .wrsr_req(wrsr_req), .wrsr_data(wrsr_data),
        .chk_addr(chk_addr), .status_byte(status_byte), .hw_prot(hw_prot),
        .addr_prot(addr_prot)
    );

    typedef struct {
        logic [7:0] st;
        logic       hp;
        logic       ap;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // Driver: inputs already set just after a negedge; push what the
    // next posedge must produce, then move to the following negedge.
    task automatic go(string tag, logic [7:0] st, logic hp, logic ap);
        exp_t e;
        e.st = st; e.hp = hp; e.ap = ap; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        wren_req = 1'b0;
        wrsr_req = 1'b0;
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_NS/4);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (status_byte !== e.st || hw_prot !== e.hp || addr_prot !== e.ap) begin
                    bad++;
                    $display("FAIL %s: got st=%h hp=%b ap=%b exp st=%h hp=%b ap=%b",
                             e.tag, status_byte, hw_prot, addr_prot, e.st, e.hp, e.ap);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_addr = 12'hFFF;
        // R1 reset state
        go("R1 reset", 8'h00, 1'b0, 1'b0);

        // R3 write without WEL ignored
        wrsr_req = 1'b1; wrsr_data = 8'h9C;
        go("R3 no WEL", 8'h00, 1'b0, 1'b0);

        // R2 set WEL
        wren_req = 1'b1;
        go("R2 wren", 8'h02, 1'b0, 1'b0);

        // R4/R5 accepted write with SRWD=1 BP=011, pin high (R9)
        wrsr_req = 1'b1; wrsr_data = 8'h8C;
        go("R4 load", 8'h8F, 1'b0, 1'b1);
        for (int i = 1; i < WRC; i++) go("R5 wip held", 8'h8F, 1'b0, 1'b1);
        go("R5 wip end wel clr", 8'h8C, 1'b0, 1'b1);
        go("R9 pin high no hpm", 8'h8C, 1'b0, 1'b1);

        // R11 region for code 3: top 256
        chk_addr = 12'hF00;
        go("R11 code3 inside", 8'h8C, 1'b0, 1'b1);
        chk_addr = 12'hEFF;
        go("R11 code3 outside", 8'h8C, 1'b0, 1'b0);

        // R6 pin low after SRWD: two edges of latency
        wp_n_pin = 1'b0;
        go("R6 sync stage1", 8'h8C, 1'b0, 1'b0);
        go("R6 hpm entered", 8'h8C, 1'b1, 1'b0);

        // R7 refused write
        wren_req = 1'b1;
        go("R2 wren in hpm", 8'h8E, 1'b1, 1'b0);
        wrsr_req = 1'b1; wrsr_data = 8'h00;
        go("R7 refused", 8'h8C, 1'b1, 1'b0);
        go("R7 no wip", 8'h8C, 1'b1, 1'b0);

        // R8 exit by pin high only
        wp_n_pin = 1'b1;
        go("R8 still hpm", 8'h8C, 1'b1, 1'b0);
        go("R8 exited", 8'h8C, 1'b0, 1'b0);
        wren_req = 1'b1;
        go("R2 wren", 8'h8E, 1'b0, 1'b0);
        wrsr_req = 1'b1; wrsr_data = 8'h00;
        go("R8 clear srwd", 8'h03, 1'b0, 1'b0);
        for (int i = 1; i < WRC; i++) go("R5 wip held", 8'h03, 1'b0, 1'b0);
        go("R5 wip end", 8'h00, 1'b0, 1'b0);

        // R6 other order: pin low first, then SRWD set
        wp_n_pin = 1'b0;
        go("R6 pin low", 8'h00, 1'b0, 1'b0);
        go("R6 pin low srwd0", 8'h00, 1'b0, 1'b0);
        wren_req = 1'b1;
        go("R2 wren", 8'h02, 1'b0, 1'b0);
        wrsr_req = 1'b1; wrsr_data = 8'h9C;
        chk_addr = 12'h000;
        go("R6 srwd second", 8'h9F, 1'b1, 1'b1);
        for (int i = 1; i < WRC; i++) go("R5 wip held", 8'h9F, 1'b1, 1'b1);
        go("R5 wip end", 8'h9C, 1'b1, 1'b1);
        wp_n_pin = 1'b1;
        go("R8 leaving", 8'h9C, 1'b1, 1'b1);
        go("R8 left", 8'h9C, 1'b0, 1'b1);

        // R4 reserved bits ignored, R11 code 1 edges
        wren_req = 1'b1;
        go("R2 wren", 8'h9E, 1'b0, 1'b1);
        wrsr_req = 1'b1; wrsr_data = 8'h64;
        chk_addr = 12'hFC0;
        go("R4 rsvd zero", 8'h07, 1'b0, 1'b1);
        for (int i = 1; i < WRC; i++) go("R5 wip held", 8'h07, 1'b0, 1'b1);
        chk_addr = 12'hFBF;
        go("R11 code1 outside", 8'h04, 1'b0, 1'b0);

        // R10 external busy: wip at once, requests ignored
        ext_busy = 1'b1;
        wren_req = 1'b1;
        go("R10 busy wren ignored", 8'h05, 1'b0, 1'b0);
        ext_busy = 1'b0;
        go("R10 busy released", 8'h04, 1'b0, 1'b0);
        wren_req = 1'b1;
        go("R2 wren", 8'h06, 1'b0, 1'b0);
        ext_busy = 1'b1;
        wrsr_req = 1'b1; wrsr_data = 8'h00;
        go("R10 busy write ignored", 8'h07, 1'b0, 1'b0);
        ext_busy = 1'b0;
        wrsr_req = 1'b1; wrsr_data = 8'h00;
        chk_addr = 12'hFFF;
        go("R11 code0 none", 8'h03, 1'b0, 1'b0);
        for (int i = 1; i < WRC; i++) go("R5 wip held", 8'h03, 1'b0, 1'b0);
        go("R5 wip end", 8'h00, 1'b0, 1'b0);

        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule